// File: doc/BRIEF.md
# Clock-Correcting Receive Elastic Buffer

This block sits behind the 8b/10b decoder of a gigabit Ethernet receiver. Decoded code-groups (a data byte plus a control flag) arrive on the recovered clock and leave on the local read clock. Gray-coded pointers cross between the two domains. The read side tracks how full the buffer is and steers the fill back toward the middle. When the buffer is too full it drops a whole two-code-group correction pair. When it is too empty it plays one pair a second time. Single words are never added or removed.

The main correction pair is the idle pair: comma K28.5 followed by data D16.2. A configuration input also lets the buffer correct on the comma + D21.5 pair, which is how the first half of a configuration ordered set begins. This keeps correction going during auto-negotiation, when no idles are sent. Every correction is reported on a 3-bit status port so a downstream state machine can expect the ordered-set fragment it causes. Buffer overrun and underrun are reported on a second 3-bit port. Either error re-centres the buffer.

Top module: `rx_elastic_buf`

## Requirements
- R1: After reset, `rd_valid` is 0 and both status ports are 000. No code-group is delivered until the read side has seen at least 16 entries (half of the 32-entry depth) written.
- R2: Outside correction and error events, delivered code-groups appear in exactly the order written, with `rd_k` equal to the written control flag.
- R3: When the fill level is above 20, at least 3 entries are present, and the next two unread entries are {K=1, 0xBC} then {K=0, 0x50}, that pair is skipped. The third entry is delivered in its place, and `clkcor_stat` shows 010 alongside it.
- R4: When the fill level is below 12, at least 2 entries are present, and the next two unread entries form a correction pair, the pair is delivered twice in a row (K, D, K, D). `clkcor_stat` shows 001 alongside the first comma.
- R5: The pair {K=1, 0xBC} then {K=0, 0xB5} counts as a correction pair only while `cfg_alt_seq_en` is 1.
- R6: A matching byte with the wrong control flag is not a correction pair. For example, 0x50 with K=1 after the comma is not matched.
- R7: `clkcor_stat` only takes the values 000, 001 and 010. Each event code is held for exactly one read cycle, and two events are never back to back.
- R8: When the read-side fill level reaches 30, `buf_stat` shows 110 for one cycle. No code-group is delivered in that cycle, and the buffer resumes at a fill of 16 from the newest written entries.
- R9: When the read side finds the buffer empty, `buf_stat` shows 101 for one cycle. No code-group is delivered in that cycle, and the read pointer is moved back to a fill of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_en | input | 1 | A decoded code-group is present this cycle |
| wr_data | input | 8 | Decoded byte |
| wr_k | input | 1 | Control flag of the decoded byte |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| cfg_alt_seq_en | input | 1 | Also correct on comma + D21.5 (read domain, static) |
| rd_valid | output | 1 | A code-group is delivered this cycle |
| rd_data | output | 8 | Delivered byte |
| rd_k | output | 1 | Control flag of the delivered byte |
| clkcor_stat | output | 3 | Correction event: 000 none, 001 inserted pair, 010 deleted pair |
| buf_stat | output | 3 | Buffer condition: 000 normal, 101 underflow, 110 overflow |

## Verification
The hardest condition to reach is a correction decision. It needs a sustained frequency offset between the two clocks, so the fill level drifts across a threshold, together with a correction pair sitting exactly at the read pointer at that moment. The bench gives the write clock a period 2% shorter or longer than the read clock for several thousand cycles. It sends randomly interleaved idle pairs, configuration-style quads or deliberately mis-flagged pairs, so each threshold is crossed many times. Overflow needs the alternate pair disabled (or a mis-flagged pair) under a fast writer. Underflow is reached by stopping the writer.

// File: rtl/rxeb_pkg.sv
`timescale 1ns/1ps
package rxeb_pkg;
    // code-group layout: {k_flag, byte}
    localparam int unsigned CG_W = 9;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;  // K28.5
    localparam logic [7:0] IDLE2_BYTE = 8'h50;  // D16.2
    localparam logic [7:0] CFG1_BYTE  = 8'hB5;  // D21.5

    typedef enum logic [2:0] {
        CC_NONE = 3'b000,
        CC_INS  = 3'b001,
        CC_DEL  = 3'b010
    } cc_code_e;

    typedef enum logic [2:0] {
        BS_OK    = 3'b000,
        BS_UNDER = 3'b101,
        BS_OVER  = 3'b110
    } bs_code_e;

    typedef enum logic {
        RD_PRIME = 1'b0,
        RD_RUN   = 1'b1
    } rd_phase_e;
endpackage

// File: rtl/rxeb_dpram.sv
`timescale 1ns/1ps
module rxeb_dpram #(
    parameter int unsigned W   = 9,
    parameter int unsigned AW  = 5,
    parameter int unsigned NRD = 3
) (
    input  logic                   wr_clk,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [W-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0] rd_addr,
    output logic [NRD-1:0][W-1:0]  rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // one asynchronous look-ahead port per consecutive slot
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = mem[rd_addr[g]];
    end
endmodule

// File: rtl/rxeb_ptr_sync.sv
`timescale 1ns/1ps
module rxeb_ptr_sync #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_regs_t;

    sync_regs_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = gray_in;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ sy_q.s2[i];
            bin_out[i] = acc;
        end
    end
endmodule

// File: rtl/rxeb_pair_match.sv
`timescale 1ns/1ps
module rxeb_pair_match
    import rxeb_pkg::*;
(
    input  logic [CG_W-1:0] first_cg,
    input  logic [CG_W-1:0] second_cg,
    input  logic            alt_en,
    output logic            hit
);
    logic lead_ok, idle_ok, cfg_ok;

    always_comb begin
        lead_ok = (first_cg  == {1'b1, COMMA_BYTE});
        idle_ok = (second_cg == {1'b0, IDLE2_BYTE});
        cfg_ok  = alt_en && (second_cg == {1'b0, CFG1_BYTE});
        hit     = lead_ok && (idle_ok || cfg_ok);
    end
endmodule

// File: rtl/rx_elastic_buf.sv
`timescale 1ns/1ps
module rx_elastic_buf
    import rxeb_pkg::*;
#(
    parameter int unsigned AW         = 5,
    parameter int unsigned HI_MARK    = 20,
    parameter int unsigned LO_MARK    = 12,
    parameter int unsigned OVF_MARGIN = 2
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_k,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    input  logic       cfg_alt_seq_en,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_k,
    output logic [2:0] clkcor_stat,
    output logic [2:0] buf_stat
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned NLOOK = 3;
    localparam logic [PW-1:0] HALF_P = PW'(DEPTH / 2);
    localparam logic [PW-1:0] HI_P   = PW'(HI_MARK);
    localparam logic [PW-1:0] LO_P   = PW'(LO_MARK);
    localparam logic [PW-1:0] OVF_P  = PW'(DEPTH - OVF_MARGIN);
    localparam logic [PW-1:0] ONE_P  = PW'(1);
    localparam logic [PW-1:0] TWO_P  = PW'(2);
    localparam logic [PW-1:0] THREE_P = PW'(3);

    // ---------------- write domain ----------------
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
    } wr_regs_t;

    wr_regs_t wr_d, wr_q;

    always_comb begin
        wr_d      = wr_q;
        wr_d.ptr  = wr_q.ptr + (wr_en ? ONE_P : '0);
        wr_d.gray = wr_d.ptr ^ (wr_d.ptr >> 1);
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) wr_q <= '0;
        else           wr_q <= wr_d;
    end

    // ---------------- storage ----------------
    logic [NLOOK-1:0][AW-1:0]   look_addr;
    logic [NLOOK-1:0][CG_W-1:0] look_cg;

    rxeb_dpram #(.W(CG_W), .AW(AW), .NRD(NLOOK)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_q.ptr[AW-1:0]),
        .wr_data ({wr_k, wr_data}),
        .rd_addr (look_addr),
        .rd_data (look_cg)
    );

    // ---------------- read domain ----------------
    logic [PW-1:0] wbin_rd;

    rxeb_ptr_sync #(.W(PW)) u_wsync (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wr_q.gray),
        .bin_out (wbin_rd)
    );

    typedef struct packed {
        rd_phase_e       phase;
        logic [PW-1:0]   rptr;
        logic            rewind;
        logic [1:0]      lock;
        logic [CG_W-1:0] dout;
        logic            vld;
        cc_code_e        cc;
        bs_code_e        bs;
    } rd_regs_t;

    localparam rd_regs_t RD_RST = '{phase: RD_PRIME, rptr: '0, rewind: 1'b0,
                                    lock: 2'd0, dout: '0, vld: 1'b0,
                                    cc: CC_NONE, bs: BS_OK};

    rd_regs_t rd_d, rd_q;
    logic [PW-1:0] fill;
    logic          pair_hit;
    logic          may_fix;

    for (genvar g = 0; g < NLOOK; g++) begin : g_look
        assign look_addr[g] = rd_q.rptr[AW-1:0] + AW'(g);
    end

    rxeb_pair_match u_match (
        .first_cg  (look_cg[0]),
        .second_cg (look_cg[1]),
        .alt_en    (cfg_alt_seq_en),
        .hit       (pair_hit)
    );

    assign fill    = wbin_rd - rd_q.rptr;
    assign may_fix = (rd_q.lock == 2'd0) && pair_hit;

    always_comb begin
        rd_d        = rd_q;
        rd_d.vld    = 1'b0;
        rd_d.cc     = CC_NONE;
        rd_d.bs     = BS_OK;
        rd_d.rewind = 1'b0;
        if (rd_q.lock != 2'd0) rd_d.lock = rd_q.lock - 2'd1;

        case (rd_q.phase)
            RD_PRIME: begin
                if (fill >= HALF_P) rd_d.phase = RD_RUN;
            end
            RD_RUN: begin
                if (rd_q.rewind) begin
                    // second half of a repeated pair, then step back to its comma
                    rd_d.dout = look_cg[0];
                    rd_d.vld  = 1'b1;
                    rd_d.rptr = rd_q.rptr - ONE_P;
                end else if (fill == '0) begin
                    rd_d.bs   = BS_UNDER;
                    rd_d.rptr = wbin_rd - HALF_P;
                end else if (fill >= OVF_P) begin
                    rd_d.bs   = BS_OVER;
                    rd_d.rptr = wbin_rd - HALF_P;
                end else if (may_fix && fill > HI_P && fill >= THREE_P) begin
                    rd_d.dout = look_cg[2];
                    rd_d.vld  = 1'b1;
                    rd_d.rptr = rd_q.rptr + THREE_P;
                    rd_d.cc   = CC_DEL;
                    rd_d.lock = 2'd2;
                end else if (may_fix && fill < LO_P && fill >= TWO_P) begin
                    rd_d.dout   = look_cg[0];
                    rd_d.vld    = 1'b1;
                    rd_d.rptr   = rd_q.rptr + ONE_P;
                    rd_d.rewind = 1'b1;
                    rd_d.cc     = CC_INS;
                    rd_d.lock   = 2'd3;
                end else begin
                    rd_d.dout = look_cg[0];
                    rd_d.vld  = 1'b1;
                    rd_d.rptr = rd_q.rptr + ONE_P;
                end
            end
            default: rd_d.phase = RD_PRIME;
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) rd_q <= RD_RST;
        else           rd_q <= rd_d;
    end

    assign rd_valid    = rd_q.vld;
    assign rd_data     = rd_q.dout[7:0];
    assign rd_k        = rd_q.dout[8];
    assign clkcor_stat = rd_q.cc;
    assign buf_stat    = rd_q.bs;
endmodule

// File: rtl/rxeb_chk.sv
`timescale 1ns/1ps
module rxeb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_valid,
    input logic [2:0] cc,
    input logic [2:0] bs
);
    // R7
    cc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc != 3'b000) |=> (cc == 3'b000));

    // R7
    cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc == 3'b000) || (cc == 3'b001) || (cc == 3'b010));

    // R8
    bs_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bs == 3'b000) || (bs == 3'b101) || (bs == 3'b110));

    // R9
    err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bs != 3'b000) |-> !rd_valid);

    // R8
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bs != 3'b000) |=> (bs == 3'b000));

    // R3
    event_carries_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc != 3'b000) |-> (rd_valid && bs == 3'b000));
endmodule

bind rx_elastic_buf rxeb_chk u_chk (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .rd_valid (rd_valid),
    .cc       (clkcor_stat),
    .bs       (buf_stat)
);

// File: tb/rx_elastic_buf_tb.sv
`timescale 1ns/1ps
module rx_elastic_buf_tb;
    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_k = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cfg_alt_seq_en = 1'b1;
    logic       rd_valid, rd_k;
    logic [7:0] rd_data;
    logic [2:0] clkcor_stat, buf_stat;

    rx_elastic_buf u_dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_k(wr_k), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .cfg_alt_seq_en(cfg_alt_seq_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_k(rd_k), .clkcor_stat(clkcor_stat), .buf_stat(buf_stat)
    );

    real wr_half = 2.5;
    always #2.5 rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int n_ins, n_del, n_ovf, n_unf, n_cmp, n_blank_err;
    int mode = 0;
    bit gen_on = 1'b0, mon_on = 1'b0, stream_on = 1'b0, resync = 1'b0;
    logic [2:0] prev_cc = 3'b000;
    logic [7:0] cnt = 8'h00;
    logic [8:0] pend[$];
    logic [8:0] expq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] next_cnt(input logic [7:0] c);
        logic [7:0] v;
        v = c + 8'd1;
        while (v == 8'h50 || v == 8'hB5 || v == 8'hBC) v = v + 8'd1;
        return v;
    endfunction

    function automatic bit second_ok(input logic [8:0] cg);
        return (cg == {1'b0, 8'h50}) || (cfg_alt_seq_en && cg == {1'b0, 8'hB5});
    endfunction

    task automatic refill();
        case (mode)
            1: begin
                pend.push_back({1'b1, 8'hBC}); pend.push_back({1'b0, 8'hB5});
                cnt = next_cnt(cnt); pend.push_back({1'b0, cnt});
                cnt = next_cnt(cnt); pend.push_back({1'b0, cnt});
            end
            2: begin
                if ($urandom % 3 == 0) begin
                    pend.push_back({1'b1, 8'hBC}); pend.push_back({1'b1, 8'h50});
                end else begin
                    cnt = next_cnt(cnt); pend.push_back({1'b0, cnt});
                end
            end
            default: begin
                if ($urandom % 3 == 0) begin
                    pend.push_back({1'b1, 8'hBC}); pend.push_back({1'b0, 8'h50});
                end else begin
                    cnt = next_cnt(cnt); pend.push_back({1'b0, cnt});
                end
            end
        endcase
    endtask

    // stimulus: one code-group per write cycle, pairs kept whole
    always @(negedge wr_clk) begin
        logic [8:0] w;
        if (!wr_rst_n || !gen_on) begin
            wr_en = 1'b0;
        end else begin
            if (pend.size() == 0) refill();
            w = pend.pop_front();
            wr_en = 1'b1;
            {wr_k, wr_data} = w;
            expq.push_back(w);
        end
    end

    // output monitor
    always @(negedge rd_clk) begin
        logic [8:0] got;
        int idx;
        if (mon_on) begin
            got = {rd_k, rd_data};
            if (clkcor_stat == 3'b001) n_ins++;
            if (clkcor_stat == 3'b010) n_del++;
            if (buf_stat == 3'b110) n_ovf++;
            if (buf_stat == 3'b101) n_unf++;
            if (buf_stat != 3'b000 && rd_valid) n_blank_err++;
            if (clkcor_stat != 3'b000 && prev_cc != 3'b000)
                check(1'b0, "R7 back-to-back event", clkcor_stat, 0);
            prev_cc = clkcor_stat;
            if (stream_on) begin
                if (buf_stat != 3'b000) begin
                    resync = 1'b1;
                end else if (rd_valid && resync) begin
                    if (!(rd_k || rd_data == 8'h50 || rd_data == 8'hB5)) begin
                        idx = -1;
                        for (int i = 0; i < expq.size(); i++)
                            if (idx < 0 && expq[i] == got) idx = i;
                        if (idx >= 0) begin
                            for (int j = 0; j <= idx; j++) void'(expq.pop_front());
                            resync = 1'b0;
                        end
                    end
                end else if (rd_valid) begin
                    n_cmp++;
                    if (clkcor_stat == 3'b010) begin
                        // R3: matched pair dropped, third entry delivered
                        check(expq.size() >= 3 && expq[0] == {1'b1, 8'hBC} && second_ok(expq[1]),
                              "R3 deleted pair", (expq.size() >= 2) ? int'(expq[1]) : -1, 9'h050);
                        if (expq.size() >= 3) begin
                            void'(expq.pop_front()); void'(expq.pop_front());
                            check(got == expq[0], "R3 data after deletion", got, expq[0]);
                            void'(expq.pop_front());
                        end
                    end else if (clkcor_stat == 3'b001) begin
                        // R4: pair repeated K, D, K, D
                        check(expq.size() >= 2 && got == {1'b1, 8'hBC} && expq[0] == got && second_ok(expq[1]),
                              "R4 inserted pair", got, 9'h1BC);
                        if (expq.size() >= 2) begin
                            logic [8:0] k0, d0;
                            k0 = expq.pop_front();
                            d0 = expq[0];
                            expq.insert(1, k0);
                            expq.insert(2, d0);
                        end
                    end else begin
                        // R2: in-order delivery
                        if (expq.size() == 0) check(1'b0, "R2 unexpected data", got, 0);
                        else begin
                            check(got == expq[0], "R2 stream order", got, expq[0]);
                            void'(expq.pop_front());
                        end
                    end
                end
            end
        end
    end

    task automatic start_scn(input real half, input int md, input bit alt);
        gen_on = 1'b0; mon_on = 1'b0; stream_on = 1'b0;
        @(negedge rd_clk);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        wr_half = half; mode = md; cfg_alt_seq_en = alt;
        repeat (4) @(negedge rd_clk);
        pend.delete(); expq.delete();
        n_ins = 0; n_del = 0; n_ovf = 0; n_unf = 0; n_cmp = 0; n_blank_err = 0;
        resync = 1'b0; prev_cc = 3'b000;
        // R1: reset state
        check(rd_valid == 1'b0 && clkcor_stat == 3'b000 && buf_stat == 3'b000,
              "R1 reset outputs", {rd_valid, clkcor_stat, buf_stat}, 0);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge rd_clk);
        gen_on = 1'b1; mon_on = 1'b1; stream_on = 1'b1;
        begin
            bit early = 1'b0;
            repeat (10) begin
                @(negedge rd_clk);
                if (rd_valid) early = 1'b1;
            end
            // R1: nothing delivered before half the depth is written
            check(!early, "R1 priming", early, 0);
        end
    endtask

    task automatic run_for(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // watchdog
    always @(posedge rd_clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected<=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));

        // matched clocks: no corrections, no errors
        start_scn(2.5, 0, 1'b1);
        run_for(2000);
        check(n_ins == 0 && n_del == 0, "R3 R4 quiet inside band", n_ins + n_del, 0);
        check(n_ovf == 0 && n_unf == 0, "R8 R9 no error at matched rate", n_ovf + n_unf, 0);
        check(n_cmp > 1500, "R2 stream delivered", n_cmp, 1500);

        // fast writer with idle pairs: deletions
        start_scn(2.45, 0, 1'b1);
        run_for(3000);
        check(n_del > 0, "R3 deletions under fast writer", n_del, 1);
        check(n_ovf == 0, "R8 deletion prevents overflow", n_ovf, 0);

        // slow writer with idle pairs: insertions
        start_scn(2.55, 0, 1'b1);
        run_for(3000);
        check(n_ins > 0, "R4 insertions under slow writer", n_ins, 1);
        check(n_unf == 0, "R9 insertion prevents underflow", n_unf, 0);

        // configuration pairs with alternate sequence enabled
        start_scn(2.45, 1, 1'b1);
        run_for(3000);
        check(n_del > 0, "R5 alternate pair deleted when enabled", n_del, 1);
        check(n_ovf == 0, "R5 no overflow when enabled", n_ovf, 0);

        // configuration pairs with alternate sequence disabled
        start_scn(2.45, 1, 1'b0);
        run_for(3000);
        check(n_del == 0 && n_ins == 0, "R5 alternate pair ignored when disabled", n_del + n_ins, 0);
        check(n_ovf > 0, "R8 overflow reported", n_ovf, 1);
        check(n_blank_err == 0, "R8 no data on error cycle", n_blank_err, 0);

        // mis-flagged pair must not match
        start_scn(2.45, 2, 1'b1);
        run_for(3000);
        check(n_del == 0, "R6 wrong K flag not matched", n_del, 0);
        check(n_ovf > 0, "R6 R8 overflow without correction", n_ovf, 1);

        // writer stops: underflow
        start_scn(2.5, 0, 1'b1);
        run_for(300);
        stream_on = 1'b0;
        gen_on = 1'b0;
        run_for(200);
        check(n_unf > 0, "R9 underflow reported", n_unf, 1);
        check(n_blank_err == 0, "R9 no data on error cycle", n_blank_err, 0);

        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule